// File: doc/BRIEF.md
# Dual-channel rate tick generator with polled interrupt request

This block serves a pair of asynchronous serial channels that run from one master clock. A single write-only configuration byte picks a 3-bit rate code and an interrupt enable for each channel. Eight rate streams, one for each supported baud rate at sixteen times that rate, run side by side from free-running divide counters. Each channel selects its own stream, so the two channels never constrain each other. A channel's transmit and receive halves share the one tick it is given.

The same byte gates the interrupt. A channel raises the shared active-low request while its enable is set and either of its ready flags is true. There is no acknowledge path. Software finds the source by reading channel status, and the request drops once it writes or reads the data that cleared the flag. A new rate code does not cut into a running tick period: the channel switches streams only at a tick of the stream it is already using.

Top module: `baud_irq_ctrl`

## Requirements
- R1: After reset the configuration byte is all zeros, so both interrupt enables are off and both channels use code 000. `irq_n` is high whatever the ready inputs are.
- R2: A write stores `cfg_wdata` with this layout: bit 7 is the channel A enable, bits [6:4] the channel A code, bit 3 the channel B enable and bits [2:0] the channel B code. The byte keeps its value while `cfg_we` is low.
- R3: Codes 0 through 7 select 110, 150, 300, 1200, 1800, 2400, 4800 and 9600 baud. A channel's tick repeats every round(CLK_HZ / (16 × baud)) cycles, which for the default 1,843,200 Hz is 1047, 768, 384, 96, 64, 48, 24 and 12 cycles.
- R4: Each tick is high for exactly one clock cycle.
- R5: The two channels' rates are independent. Changing one channel's code leaves the other channel's tick period unchanged.
- R6: `irq_n` is low when channel A's enable is set and `txrdy_a` or `rxrdy_a` is high, or when channel B's enable is set and `txrdy_b` or `rxrdy_b` is high.
- R7: A ready flag of a channel whose enable is clear has no effect on `irq_n`.
- R8: The request is a level. It stays low for as long as the condition lasts and goes high once the ready flags drop, with no acknowledge.
- R9: A new code takes effect at the next tick of the channel's current rate. The gap that was running when the write happened keeps the old length, and once the new stream has ticked, later gaps have the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte |
| txrdy_a | input | 1 | Channel A transmit ready |
| rxrdy_a | input | 1 | Channel A receive ready |
| txrdy_b | input | 1 | Channel B transmit ready |
| rxrdy_b | input | 1 | Channel B receive ready |
| tick_a | output | 1 | Channel A 16x rate tick |
| tick_b | output | 1 | Channel B 16x rate tick |
| irq_n | output | 1 | Active-low combined interrupt request |

## Verification
The interrupt path is driven with one table of configuration bytes and ready-flag patterns. The table pairs each flag with its own channel's enable and with the other channel's enable, which separates correct gating from crossed or missing enables. Every code is measured as a tick gap on both channels at once, with the two channels always on different codes, so a shared or swapped multiplexer shows up as a wrong period. A code change is written just after a tick, and the gap that follows must still have the old length. This separates switching at the tick boundary from switching immediately.

// File: rtl/baud_irq_ctrl.sv
module baud_irq_ctrl #(
  parameter int CLK_HZ = 1_843_200,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       txrdy_a,
  input  logic       rxrdy_a,
  input  logic       txrdy_b,
  input  logic       rxrdy_b,
  output logic       tick_a,
  output logic       tick_b,
  output logic       irq_n
);

  localparam int NRATES = 8;

  function automatic int baud_of(input int k);
    case (k)
      0: return 110;
      1: return 150;
      2: return 300;
      3: return 1200;
      4: return 1800;
      5: return 2400;
      6: return 4800;
      default: return 9600;
    endcase
  endfunction

  function automatic int div_of(input int k);
    longint r;
    r = longint'(OVERSAMPLE) * baud_of(k);
    return int'((longint'(CLK_HZ) + r / 2) / r);
  endfunction

  localparam int CW = $clog2(div_of(0)) + 1;

  logic [7:0]        cfg_q;
  logic [NRATES-1:0] rate_tick;
  logic [2:0]        act_a, act_b;

  wire       en_a   = cfg_q[7];
  wire [2:0] code_a = cfg_q[6:4];
  wire       en_b   = cfg_q[3];
  wire [2:0] code_b = cfg_q[2:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;

  for (genvar g = 0; g < NRATES; g++) begin : g_rate
    localparam int DIV = div_of(g);
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt          <= '0;
        rate_tick[g] <= 1'b0;
      end else begin
        rate_tick[g] <= (cnt == CW'(DIV - 1));
        cnt          <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
      end

    p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rate_tick[g] |=> !rate_tick[g]);
  end

  assign tick_a = rate_tick[act_a];
  assign tick_b = rate_tick[act_b];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
    end else begin
      if (tick_a) act_a <= code_a;
      if (tick_b) act_b <= code_b;
    end

  assign irq_n = ~((en_a & (txrdy_a | rxrdy_a)) | (en_b & (txrdy_b | rxrdy_b)));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

  p_switch_at_tick_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_a |=> $stable(act_a));

  p_switch_at_tick_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_b |=> $stable(act_b));

  p_take_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a |=> act_a == $past(code_a));

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable({cfg_q, txrdy_a, rxrdy_a, txrdy_b, rxrdy_b}) |-> $stable(irq_n));

  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[7] && !cfg_q[3]) |-> irq_n);

endmodule

// File: tb/tb_baud_irq_ctrl.sv
module tb_baud_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic txrdy_a = 1'b0, rxrdy_a = 1'b0, txrdy_b = 1'b0, rxrdy_b = 1'b0;
  logic tick_a, tick_b, irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  baud_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .txrdy_a(txrdy_a), .rxrdy_a(rxrdy_a), .txrdy_b(txrdy_b), .rxrdy_b(rxrdy_b),
    .tick_a(tick_a), .tick_b(tick_b), .irq_n(irq_n)
  );

  localparam int PERIOD [8] = '{1047, 768, 384, 96, 64, 48, 24, 12};

  // {cfg byte, {txa,rxa,txb,rxb}, expected irq_n}
  localparam logic [12:0] VEC [12] = '{
    {8'h00, 4'hF, 1'b1}, {8'h80, 4'h8, 1'b0}, {8'h80, 4'h4, 1'b0},
    {8'h80, 4'h3, 1'b1}, {8'h08, 4'h1, 1'b0}, {8'h08, 4'h2, 1'b0},
    {8'h08, 4'hC, 1'b1}, {8'h88, 4'h0, 1'b1}, {8'h88, 4'h5, 1'b0},
    {8'h77, 4'hF, 1'b1}, {8'h88, 4'hF, 1'b0}, {8'h80, 4'h0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_rdy(input logic [3:0] r);
    {txrdy_a, rxrdy_a, txrdy_b, rxrdy_b} = r;
  endtask

  function automatic logic tk(input bit ch);
    return ch ? tick_b : tick_a;
  endfunction

  task automatic wait_tick(input bit ch);
    do @(negedge clk); while (!tk(ch));
  endtask

  task automatic gap(input bit ch, output int n, output int width_ok);
    n = 0;
    width_ok = 1;
    @(negedge clk);
    if (tk(ch)) width_ok = 0;
    n = 1;
    while (!tk(ch)) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic settle_measure(input bit ch, output int n, output int w);
    wait_tick(ch);
    wait_tick(ch);
    wait_tick(ch);
    gap(ch, n, w);
  endtask

  initial begin
    repeat (2_000_000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, w, n2, w2;
    set_rdy(4'hF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq_n after reset", irq_n, 1);
    gap(0, n, w);
    gap(0, n, w);
    check("R1 channel A code 000 period", n, PERIOD[0]);
    gap(1, n, w);
    gap(1, n, w);
    check("R1 channel B code 000 period", n, PERIOD[0]);

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][12:5]);
      set_rdy(VEC[i][4:1]);
      @(negedge clk);
      check($sformatf("R6 R7 R2 vector %0d irq_n", i), irq_n, VEC[i][0]);
    end

    wr(8'h08);
    set_rdy(4'h1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_n !== 1'b0) check("R8 level held", irq_n, 0);
    end
    check("R8 still low after hold", irq_n, 0);
    set_rdy(4'h0);
    @(negedge clk);
    check("R8 released when flag drops", irq_n, 1);
    set_rdy(4'h2);
    wr(8'h00);
    @(negedge clk);
    check("R7 cleared enable masks B", irq_n, 1);
    set_rdy(4'h0);

    for (int c = 0; c < 8; c++) begin
      wr({1'b0, 3'(c), 1'b0, 3'(7 - c)});
      settle_measure(0, n, w);
      check($sformatf("R3 R5 channel A code %0d period", c), n, PERIOD[c]);
      check($sformatf("R4 channel A code %0d single-cycle", c), w, 1);
      settle_measure(1, n2, w2);
      check($sformatf("R3 R5 channel B code %0d period", 7 - c), n2, PERIOD[7 - c]);
    end

    wr(8'h35);
    settle_measure(0, n, w);
    settle_measure(1, n2, w2);
    check("R5 A period code 3", n, PERIOD[3]);
    wr(8'h31);
    settle_measure(0, n, w);
    check("R5 A unchanged after B write", n, PERIOD[3]);
    settle_measure(1, n2, w2);
    check("R5 B new code 1", n2, PERIOD[1]);

    wr(8'h01);
    settle_measure(0, n, w);
    check("R9 A settled on code 0", n, PERIOD[0]);
    // n-gap loop ended at a negedge where tick_a is high: write right here
    cfg_we = 1'b1;
    cfg_wdata = 8'h71;
    @(negedge clk);
    cfg_we = 1'b0;
    n = 1;
    while (!tick_a) begin
      @(negedge clk);
      n++;
    end
    check("R9 old-rate gap kept", n, PERIOD[0]);
    gap(0, n, w);
    check("R9 first switch gap bounded", (n >= 1 && n <= PERIOD[7]) ? 1 : 0, 1);
    gap(0, n, w);
    check("R9 new rate after switch", n, PERIOD[7]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule